// File: doc/BRIEF.md
# Hub Downstream Port Power and Overcurrent Manager

This block switches the shared supply of a four-port hub's downstream connectors. Decoded host requests arrive as one-cycle strobes that turn power on or off for a chosen port. The supply is ganged, so the block keeps one request bit per port and drives a single active-low switch enable. The supply is on while any request bit is set and no fault is present.

One global, active-low overcurrent pin reports faults for all ports together. The pin passes through a two-flop synchronizer and then a stability filter before the block acts on it. When a fault is accepted, the block drops the switch enable and clears every request bit. In the same cycle it raises the hub overcurrent status bit and the sticky overcurrent change bit.

The block also drives an active-low status LED. The LED is lit while the hub is configured and awake, and it is forced dark in suspend. After a fault it blinks with a 50% duty cycle. Blinking ends when the host issues a power-off request that leaves no port requesting power, or when the hub is enumerated again.

Top module: `hub_power_guard`

## Requirements
- R1: While reset is held, and right after it is released, pwrEnN is 1, ovcStatus is 0, ovcChange is 0, and statLedN is 1 while hubConfigured is 0.
- R2: A setPowerReq strobe for port reqPortIdx (0 to 3), given while ovcStatus is 0, sets that port's request bit. pwrEnN is 0 from the clock edge that samples the strobe.
- R3: A clrPowerReq strobe clears the indexed port's request bit. pwrEnN returns to 1 only after the edge at which no request bit is left set. Clearing a bit that is already clear leaves power unchanged.
- R4: The overcurrent pin is active low (0 means fault). A fault is accepted exactly FILT_CYCLES+2 clock edges after the pin first reads low, counting two synchronizer stages and FILT_CYCLES stable samples. A low pulse shorter than FILT_CYCLES cycles is ignored: ovcStatus stays 0 and power stays on.
- R5: At the edge where a fault is accepted, ovcStatus becomes 1, ovcChange becomes 1, pwrEnN becomes 1, and all request bits are cleared.
- R6: A setPowerReq strobe that arrives while ovcStatus is 1 is ignored, so pwrEnN stays 1.
- R7: ovcStatus drops to 0 once the pin has read high for FILT_CYCLES stable samples. ovcChange stays 1 until a clrOvcChange strobe arrives, and the strobe clears it at the next edge.
- R8: When no fault blink is running, statLedN is 0 while hubConfigured is 1 and hubSuspended is 0, and 1 otherwise. hubSuspended at 1 forces statLedN to 1 in every state.
- R9: From the edge that accepts a fault, the LED is lit for 2^BLINK_EXP cycles, then dark for 2^BLINK_EXP cycles, and the pattern repeats.
- R10: Blinking ends at the edge that samples a clrPowerReq leaving every request bit clear, or at the edge that samples a rising hubConfigured. After that the LED follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setPowerReq | input | 1 | One-cycle strobe: host asks for power on port reqPortIdx |
| clrPowerReq | input | 1 | One-cycle strobe: host removes power request of port reqPortIdx |
| reqPortIdx | input | 2 | Port index (0 to 3) for the request strobes |
| hubConfigured | input | 1 | Hub has been enumerated and configured |
| hubSuspended | input | 1 | Hub is in suspend |
| clrOvcChange | input | 1 | One-cycle strobe: host acknowledges the overcurrent change bit |
| ovcPinN | input | 1 | Raw overcurrent pin, low means fault |
| pwrEnN | output | 1 | Port power switch enable, active low |
| ovcStatus | output | 1 | Hub overcurrent status bit (filtered fault) |
| ovcChange | output | 1 | Sticky hub overcurrent change bit |
| statLedN | output | 1 | Status LED drive, active low |

## Verification
The hardest states to reach are the exact edge at which the filter accepts a fault, and the blink phase measured from that edge. Neither is visible at the ports until ovcStatus rises. The bench holds the pin low and counts falling edges until ovcStatus is seen, which checks the FILT_CYCLES+2 latency. It then uses that edge as the origin and samples the LED at cycle offsets that fall inside and just past a half period. The two ways blinking ends are tested separately: one with a power-off request after a fault, one with a configured-flag drop and rise during a second fault. In both cases two samples half a period apart must read the same lit value.

// File: rtl/hub_power_pkg.sv
package hub_power_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic maskSet;    // set the selected port request bit
    logic maskClr;    // clear the selected port request bit
    logic maskClrAll; // drop every request bit (fault)
    logic chgSet;     // raise the sticky change bit
    logic chgClr;     // host acknowledge of the change bit
    logic blinkRun;   // blink counter runs
  } pwrCtrlStrobes_t;

endpackage

// File: rtl/hub_power_dp.sv
module hub_power_dp
  import hub_power_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int FILT_CYCLES = 16,
  parameter int BLINK_EXP   = 22,
  localparam int IDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ovcPinN,
  input  logic [IDX_W-1:0]     portIdx,
  input  pwrCtrlStrobes_t      strb,
  output logic                 faultAccept,
  output logic                 faultActive,
  output logic [NUM_PORTS-1:0] reqMask,
  output logic                 changeBit,
  output logic                 blinkLit
);

  localparam int CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);
  localparam int BLK_W = BLINK_EXP + 1;

  // Two-flop synchronizer, idle level is high (no fault).
  logic syncA, syncB;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= ovcPinN;
      syncB <= syncA;
    end
  end

  // Stability filter: a new level is taken only after FILT_CYCLES
  // consecutive samples that differ from the accepted level.
  logic             rawFault;
  logic             differs;
  logic             lastSample;
  logic [CNT_W-1:0] stableCnt;

  assign rawFault   = ~syncB;
  assign differs    = rawFault ^ faultActive;
  assign lastSample = differs && (stableCnt == CNT_LAST);
  assign faultAccept = lastSample && rawFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCnt   <= '0;
      faultActive <= 1'b0;
    end else if (!differs) begin
      stableCnt <= '0;
    end else if (lastSample) begin
      stableCnt   <= '0;
      faultActive <= rawFault;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  // Per-port request bits; the switch is ganged over all of them.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
    logic hit;
    assign hit = (portIdx == IDX_W'(p));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqMask[p] <= 1'b0;
      end else if (strb.maskClrAll) begin
        reqMask[p] <= 1'b0;
      end else if (hit && strb.maskSet) begin
        reqMask[p] <= 1'b1;
      end else if (hit && strb.maskClr) begin
        reqMask[p] <= 1'b0;
      end
    end
  end

  // Sticky change bit: a new event wins over an acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      changeBit <= 1'b0;
    end else if (strb.chgSet) begin
      changeBit <= 1'b1;
    end else if (strb.chgClr) begin
      changeBit <= 1'b0;
    end
  end

  // Blink counter: top bit flips every 2^BLINK_EXP cycles.
  logic [BLK_W-1:0] blinkCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkCnt <= '0;
    end else if (!strb.blinkRun) begin
      blinkCnt <= '0;
    end else begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  assign blinkLit = ~blinkCnt[BLK_W-1];

endmodule

// File: rtl/hub_power_ctrl.sv
module hub_power_ctrl
  import hub_power_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 setPowerReq,
  input  logic                 clrPowerReq,
  input  logic [IDX_W-1:0]     portIdx,
  input  logic                 hubConfigured,
  input  logic                 hubSuspended,
  input  logic                 clrOvcChange,
  input  logic                 faultAccept,
  input  logic                 faultActive,
  input  logic [NUM_PORTS-1:0] reqMask,
  input  logic                 blinkLit,
  output pwrCtrlStrobes_t      strb,
  output logic                 ledOn
);

  logic                 blinkMode;
  logic                 cfgQ;
  logic                 cfgRise;
  logic [NUM_PORTS-1:0] maskAfterClr;
  logic                 clrEmpties;

  assign cfgRise      = hubConfigured && !cfgQ;
  assign maskAfterClr = reqMask & ~(NUM_PORTS'(1) << portIdx);
  assign clrEmpties   = clrPowerReq && (maskAfterClr == '0);

  always_comb begin
    strb            = '0;
    strb.maskClrAll = faultAccept;
    strb.maskSet    = setPowerReq && !faultActive && !faultAccept;
    strb.maskClr    = clrPowerReq;
    strb.chgSet     = faultAccept;
    strb.chgClr     = clrOvcChange;
    strb.blinkRun   = blinkMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkMode <= 1'b0;
      cfgQ      <= 1'b0;
    end else begin
      cfgQ <= hubConfigured;
      if (faultAccept) begin
        blinkMode <= 1'b1;
      end else if (clrEmpties || cfgRise) begin
        blinkMode <= 1'b0;
      end
    end
  end

  always_comb begin
    if (hubSuspended) begin
      ledOn = 1'b0;
    end else if (blinkMode) begin
      ledOn = blinkLit;
    end else begin
      ledOn = hubConfigured;
    end
  end

endmodule

// File: rtl/hub_power_guard.sv
module hub_power_guard
  import hub_power_pkg::*;
#(
  parameter int FILT_CYCLES = 16,
  parameter int BLINK_EXP   = 22
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       setPowerReq,
  input  logic       clrPowerReq,
  input  logic [1:0] reqPortIdx,
  input  logic       hubConfigured,
  input  logic       hubSuspended,
  input  logic       clrOvcChange,
  input  logic       ovcPinN,
  output logic       pwrEnN,
  output logic       ovcStatus,
  output logic       ovcChange,
  output logic       statLedN
);

  localparam int NUM_PORTS = 4;

  pwrCtrlStrobes_t      strb;
  logic                 faultAccept;
  logic                 faultActive;
  logic [NUM_PORTS-1:0] reqMask;
  logic                 changeBit;
  logic                 blinkLit;
  logic                 ledOn;

  hub_power_dp #(
    .NUM_PORTS  (NUM_PORTS),
    .FILT_CYCLES(FILT_CYCLES),
    .BLINK_EXP  (BLINK_EXP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ovcPinN    (ovcPinN),
    .portIdx    (reqPortIdx),
    .strb       (strb),
    .faultAccept(faultAccept),
    .faultActive(faultActive),
    .reqMask    (reqMask),
    .changeBit  (changeBit),
    .blinkLit   (blinkLit)
  );

  hub_power_ctrl #(
    .NUM_PORTS(NUM_PORTS)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .setPowerReq  (setPowerReq),
    .clrPowerReq  (clrPowerReq),
    .portIdx      (reqPortIdx),
    .hubConfigured(hubConfigured),
    .hubSuspended (hubSuspended),
    .clrOvcChange (clrOvcChange),
    .faultAccept  (faultAccept),
    .faultActive  (faultActive),
    .reqMask      (reqMask),
    .blinkLit     (blinkLit),
    .strb         (strb),
    .ledOn        (ledOn)
  );

  assign pwrEnN    = ~(|reqMask);
  assign ovcStatus = faultActive;
  assign ovcChange = changeBit;
  assign statLedN  = ~ledOn;

endmodule

// File: rtl/hub_power_guard_chk.sv
module hub_power_guard_chk (
  input logic clk,
  input logic rstN,
  input logic setPowerReq,
  input logic clrPowerReq,
  input logic clrOvcChange,
  input logic hubSuspended,
  input logic ovcPinN,
  input logic pwrEnN,
  input logic ovcStatus,
  input logic ovcChange,
  input logic statLedN
);

  // R5
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovcStatus) |-> (pwrEnN && ovcChange));

  // R6
  power_off_in_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovcStatus |-> pwrEnN);

  // R7
  change_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovcChange && !clrOvcChange) |=> ovcChange);

  // R2
  power_on_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setPowerReq && !clrPowerReq && !ovcStatus) |=> (!pwrEnN || ovcStatus));

  // R8
  suspend_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    hubSuspended |-> statLedN);

  // R4
  filtered_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovcStatus) |-> !$past(ovcPinN, 2));

endmodule

bind hub_power_guard hub_power_guard_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .setPowerReq (setPowerReq),
  .clrPowerReq (clrPowerReq),
  .clrOvcChange(clrOvcChange),
  .hubSuspended(hubSuspended),
  .ovcPinN     (ovcPinN),
  .pwrEnN      (pwrEnN),
  .ovcStatus   (ovcStatus),
  .ovcChange   (ovcChange),
  .statLedN    (statLedN)
);

// File: tb/hub_power_guard_tb.sv
module hub_power_guard_tb;

  localparam int FILT = 4;
  localparam int BEXP = 3;
  localparam int HALF = 1 << BEXP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setPowerReq = 1'b0, clrPowerReq = 1'b0, clrOvcChange = 1'b0;
  logic [1:0] reqPortIdx = 2'd0;
  logic hubConfigured = 1'b0, hubSuspended = 1'b0, ovcPinN = 1'b1;
  logic pwrEnN, ovcStatus, ovcChange, statLedN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hub_power_guard #(.FILT_CYCLES(FILT), .BLINK_EXP(BEXP)) u_dut (
    .clk(clk), .rstN(rstN), .setPowerReq(setPowerReq), .clrPowerReq(clrPowerReq),
    .reqPortIdx(reqPortIdx), .hubConfigured(hubConfigured), .hubSuspended(hubSuspended),
    .clrOvcChange(clrOvcChange), .ovcPinN(ovcPinN), .pwrEnN(pwrEnN),
    .ovcStatus(ovcStatus), .ovcChange(ovcChange), .statLedN(statLedN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {set, clr, idx[1:0], expected pwrEnN}
  localparam int NV = 10;
  localparam logic [4:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 1'b0},
    {1'b1, 1'b0, 2'd2, 1'b0},
    {1'b0, 1'b1, 2'd0, 1'b0},
    {1'b0, 1'b1, 2'd1, 1'b0},
    {1'b0, 1'b1, 2'd2, 1'b1},
    {1'b1, 1'b0, 2'd3, 1'b0},
    {1'b0, 1'b1, 2'd3, 1'b1},
    {1'b1, 1'b0, 2'd1, 1'b0},
    {1'b1, 1'b0, 2'd1, 1'b0},
    {1'b0, 1'b1, 2'd1, 1'b1}
  };

  task automatic pulseReq(input logic doSet, input logic doClr, input logic [1:0] idx);
    setPowerReq = doSet;
    clrPowerReq = doClr;
    reqPortIdx  = idx;
    @(negedge clk);
    setPowerReq = 1'b0;
    clrPowerReq = 1'b0;
  endtask

  task automatic enterFault(input string tag);
    int seen;
    seen = 0;
    ovcPinN = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (ovcStatus && seen == 0) seen = i;
      if (seen != 0) break;
    end
    chk({tag, " accept latency"}, seen, FILT + 2);
  endtask

  initial begin
    @(negedge clk);
    // R1 values under reset
    chk("R1 pwrEnN in reset", pwrEnN, 1);
    chk("R1 ovcStatus in reset", ovcStatus, 0);
    waitCycles(2);
    rstN = 1'b1;
    waitCycles(2);
    chk("R1 pwrEnN after reset", pwrEnN, 1);
    chk("R1 ovcStatus after reset", ovcStatus, 0);
    chk("R1 ovcChange after reset", ovcChange, 0);
    chk("R1 statLedN after reset", statLedN, 1);

    // R2 R3 table of request strobes
    for (int v = 0; v < NV; v++) begin
      pulseReq(VEC[v][4], VEC[v][3], VEC[v][2:1]);
      chk($sformatf("R2/R3 vector %0d pwrEnN", v), pwrEnN, VEC[v][0]);
    end

    // R8 LED follows configured and suspend
    hubConfigured = 1'b1;
    @(negedge clk);
    chk("R8 lit when configured", statLedN, 0);
    hubSuspended = 1'b1;
    @(negedge clk);
    chk("R8 dark in suspend", statLedN, 1);
    hubSuspended = 1'b0;
    @(negedge clk);
    chk("R8 lit after resume", statLedN, 0);

    // R4 short glitch ignored
    pulseReq(1'b1, 1'b0, 2'd0);
    ovcPinN = 1'b0;
    waitCycles(FILT - 1);
    ovcPinN = 1'b1;
    waitCycles(10);
    chk("R4 glitch ovcStatus", ovcStatus, 0);
    chk("R4 glitch power kept", pwrEnN, 0);

    // R4 R5 fault accepted; blink origin is this negedge (offset 0)
    enterFault("R4");
    chk("R5 power off at fault", pwrEnN, 1);
    chk("R5 change set at fault", ovcChange, 1);
    chk("R9 lit at offset 0", statLedN, 0);
    waitCycles(HALF - 1);
    chk("R9 lit at last cycle of first half", statLedN, 0);
    waitCycles(1);
    chk("R9 dark in second half", statLedN, 1);
    waitCycles(HALF);
    chk("R9 lit again after full period", statLedN, 0);
    hubSuspended = 1'b1;
    @(negedge clk);
    chk("R8 suspend darkens blink", statLedN, 1);
    hubSuspended = 1'b0;

    // R6 set ignored during fault
    pulseReq(1'b1, 1'b0, 2'd2);
    waitCycles(1);
    chk("R6 set ignored in fault", pwrEnN, 1);

    // R7 status follows pin, change sticky until acknowledge
    ovcPinN = 1'b1;
    waitCycles(FILT + 4);
    chk("R7 status released", ovcStatus, 0);
    chk("R7 change still set", ovcChange, 1);
    clrOvcChange = 1'b1;
    @(negedge clk);
    clrOvcChange = 1'b0;
    chk("R7 change cleared by ack", ovcChange, 0);

    // R10 power-off request ends blink
    pulseReq(1'b0, 1'b1, 2'd0);
    chk("R10 steady after clear request", statLedN, 0);
    waitCycles(HALF);
    chk("R10 steady half period later", statLedN, 0);

    // R2 power returns after fault clears
    pulseReq(1'b1, 1'b0, 2'd3);
    chk("R2 power back after fault", pwrEnN, 0);

    // R10 re-enumeration ends blink
    enterFault("R5 second");
    chk("R5 second fault power off", pwrEnN, 1);
    hubConfigured = 1'b0;
    @(negedge clk);
    hubConfigured = 1'b1;
    @(negedge clk);
    chk("R10 steady after re-enumeration", statLedN, 0);
    waitCycles(HALF);
    chk("R10 steady half period after re-enumeration", statLedN, 0);
    ovcPinN = 1'b1;
    waitCycles(FILT + 4);

    // R3 clearing an already-clear bit with power off keeps it off
    pulseReq(1'b0, 1'b1, 2'd1);
    chk("R3 redundant clear", pwrEnN, 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule